// File: doc/BRIEF.md
# Key-Locked GPIO Bank with Per-Pin Drive Modes

This block is a bank of general-purpose pins controlled over a plain 32-bit register bus. Each pin has an output-data bit and a two-bit drive mode. The mode selects one of four pad behaviours: input only, push-pull, pull-low-only (open-drain) or pull-high-only (open-source). Software changes the output data and the mode bits through alias registers. On these aliases a written 1 sets or clears that pin's bit, and a written 0 leaves the pin as it was.

The mode registers are guarded by a key lock. While the lock is disarmed, every write to a mode register is dropped. Software arms the lock by writing a key value to the lock register, changes direction, and then disarms the lock by writing zero. Pad inputs pass through a two-stage synchronizer before they can be read. The output-enable and output-value pins are registered, so they update one clock after the register that feeds them.

Read data is registered and appears one clock after the read strobe. The number of implemented pins is a parameter. Bits above that count read as zero and ignore writes.

Top module: `lockgpio_bank`

## Requirements
- R1: After a synchronous reset, output data, both mode registers and the lock are zero. Every pin is then a floating input, with pad_oe and pad_out all zero.
- R2: Per pin, {mode1,mode0} selects the drive. 00 floats. 01 drives the data bit. 10 drives 0 when data is 0 and floats when data is 1. 11 floats when data is 0 and drives 1 when data is 1. A floating pin shows oe=0 and out=0.
- R3: Writing 32'h0000D42F to the lock register (offset 0x00) arms the lock. A read of offset 0x00 returns the lock state in bit 31 and zero in every other bit.
- R4: Writing zero to the lock register disarms it. Any other value leaves the lock state unchanged.
- R5: Writes to offset 0x08 (mode1), 0x0C (mode0), 0x50 (mode1 clear), 0x54 (mode0 set) and 0x58 (mode0 clear) take effect only while the lock is armed. While it is disarmed they are ignored.
- R6: Offset 0x14 sets and offset 0x18 clears output-data bits, and the mode aliases set or clear mode bits. In both cases only the bits written as 1 change. Direct writes to 0x08 and 0x0C replace the whole mode register.
- R7: Bits at and above N_PINS read as 0 in every register, and writing them has no effect.
- R8: Offset 0x04 reads the pad inputs through a two-flop synchronizer. A pad change made just before clock edge k can first be read by a read strobe sampled at edge k+2.
- R9: Reads from unmapped offsets return 0, and writes to them change no state.
- R10: Read data is registered and is valid one clock after the strobe. Offsets 0x14 and 0x18 read the output data. Offsets 0x08 and 0x50 read mode1. Offsets 0x0C, 0x54 and 0x58 read mode0.
- R11: pad_oe and pad_out change one clock after the register write that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | N_PINS | Asynchronous pad input levels |
| pad_oe | output | N_PINS | Per-pin output enable |
| pad_out | output | N_PINS | Per-pin output value |

## Verification
The drive decode is tested with a mix of pins in push-pull, pull-low-only and pull-high-only modes. Flipping the data bits under each mode shows whether the enable or the value follows the data. Mode writes are repeated with the lock disarmed, armed, and after a non-key write. This separates the key compare from the release and hold paths. All-ones set and clear patterns, together with unmapped offsets, expose any leakage into unimplemented bits or stray state. Back-to-back reads after a pad change show the exact synchronizer depth.

// File: rtl/gkb_pkg.sv
package gkb_pkg;
  localparam int unsigned BUS_W = 32;
  localparam logic [BUS_W-1:0] LOCK_KEY = 32'h0000_D42F;

  localparam logic [7:0] OFS_LOCK   = 8'h00;
  localparam logic [7:0] OFS_DIN    = 8'h04;
  localparam logic [7:0] OFS_MODE1  = 8'h08;
  localparam logic [7:0] OFS_MODE0  = 8'h0C;
  localparam logic [7:0] OFS_DSET   = 8'h14;
  localparam logic [7:0] OFS_DCLR   = 8'h18;
  localparam logic [7:0] OFS_M1CLR  = 8'h50;
  localparam logic [7:0] OFS_M0SET  = 8'h54;
  localparam logic [7:0] OFS_M0CLR  = 8'h58;

  typedef enum logic [1:0] {
    DRV_FLOAT  = 2'b00,
    DRV_PUSH   = 2'b01,
    DRV_LOWONL = 2'b10,
    DRV_HIONL  = 2'b11
  } drv_mode_e;

  // returns {oe, out}
  function automatic logic [1:0] pad_decode(input drv_mode_e m, input logic d);
    logic [1:0] r;
    case (m)
      DRV_PUSH:   r = {1'b1, d};
      DRV_LOWONL: r = d ? 2'b00 : 2'b10;
      DRV_HIONL:  r = d ? 2'b11 : 2'b00;
      default:    r = 2'b00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gkb_keylock.sv
module gkb_keylock
  import gkb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_we,
  input  logic [BUS_W-1:0] lk_wdata,
  output logic             lock_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_on <= 1'b0;
    end else if (lk_we) begin
      if (lk_wdata == LOCK_KEY)      lock_on <= 1'b1;
      else if (lk_wdata == '0)       lock_on <= 1'b0;
    end
  end

  a_r3_key_arms: assert property (@(posedge clk) disable iff (rst)
    (lk_we && lk_wdata == LOCK_KEY) |=> lock_on);

  a_r4_zero_releases: assert property (@(posedge clk) disable iff (rst)
    (lk_we && lk_wdata == '0) |=> !lock_on);

  a_r4_other_holds: assert property (@(posedge clk) disable iff (rst)
    (!(lk_we && (lk_wdata == LOCK_KEY || lk_wdata == '0))) |=> $stable(lock_on));
endmodule

// File: rtl/gkb_pinregs.sv
module gkb_pinregs
  import gkb_pkg::*;
#(
  parameter int unsigned N_PINS = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wbits,
  input  logic              lock_on,
  output logic [N_PINS-1:0] dout_q,
  output logic [N_PINS-1:0] mode0_q,
  output logic [N_PINS-1:0] mode1_q
);
  logic [7:0] ofs;
  assign ofs = 8'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      mode0_q <= '0;
      mode1_q <= '0;
    end else if (we) begin
      case (ofs)
        OFS_DSET:  dout_q  <= dout_q | wbits;
        OFS_DCLR:  dout_q  <= dout_q & ~wbits;
        OFS_MODE1: if (lock_on) mode1_q <= wbits;
        OFS_M1CLR: if (lock_on) mode1_q <= mode1_q & ~wbits;
        OFS_MODE0: if (lock_on) mode0_q <= wbits;
        OFS_M0SET: if (lock_on) mode0_q <= mode0_q | wbits;
        OFS_M0CLR: if (lock_on) mode0_q <= mode0_q & ~wbits;
        default: ;
      endcase
    end
  end

  a_r5_mode_gated: assert property (@(posedge clk) disable iff (rst)
    !lock_on |=> ($stable(mode0_q) && $stable(mode1_q)));

  a_r6_set_only_ones: assert property (@(posedge clk) disable iff (rst)
    (we && ofs == OFS_DSET) |=> ((dout_q & $past(wbits)) == $past(wbits)) &&
                                ((dout_q & ~$past(wbits)) == ($past(dout_q) & ~$past(wbits))));

  a_r6_clr_only_ones: assert property (@(posedge clk) disable iff (rst)
    (we && ofs == OFS_DCLR) |=> ((dout_q & $past(wbits)) == '0) &&
                                ((dout_q & ~$past(wbits)) == ($past(dout_q) & ~$past(wbits))));
endmodule

// File: rtl/gkb_pad_drive.sv
module gkb_pad_drive
  import gkb_pkg::*;
#(
  parameter int unsigned N_PINS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] dout_q,
  input  logic [N_PINS-1:0] mode0_q,
  input  logic [N_PINS-1:0] mode1_q,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_out
);
  logic [N_PINS-1:0] oe_d, out_d;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic [1:0] dec;
    assign dec      = pad_decode(drv_mode_e'({mode1_q[i], mode0_q[i]}), dout_q[i]);
    assign oe_d[i]  = dec[1];
    assign out_d[i] = dec[0];

    a_r2_input_floats: assert property (@(posedge clk) disable iff (rst)
      ({mode1_q[i], mode0_q[i]} == 2'b00) |=> !pad_oe[i] && !pad_out[i]);

    a_r2_lowonly_never_high: assert property (@(posedge clk) disable iff (rst)
      ({mode1_q[i], mode0_q[i]} == 2'b10) |=> !pad_out[i] && (pad_oe[i] == !$past(dout_q[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= '0;
      pad_out <= '0;
    end else begin
      pad_oe  <= oe_d;
      pad_out <= out_d;
    end
  end
endmodule

// File: rtl/gkb_sync.sv
module gkb_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/lockgpio_bank.sv
module lockgpio_bank
  import gkb_pkg::*;
#(
  parameter int unsigned N_PINS = 6,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_re,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_out
);
  localparam int unsigned SYNC_STAGES = 2;

  logic              lock_on;
  logic [N_PINS-1:0] dout_q, mode0_q, mode1_q, din_s;
  logic [7:0]        ofs;

  assign ofs = 8'(bus_addr);

  gkb_keylock u_lock (
    .clk      (clk),
    .rst      (rst),
    .lk_we    (bus_we && ofs == OFS_LOCK),
    .lk_wdata (bus_wdata),
    .lock_on  (lock_on)
  );

  gkb_pinregs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we),
    .addr    (bus_addr),
    .wbits   (bus_wdata[N_PINS-1:0]),
    .lock_on (lock_on),
    .dout_q  (dout_q),
    .mode0_q (mode0_q),
    .mode1_q (mode1_q)
  );

  gkb_pad_drive #(.N_PINS(N_PINS)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .dout_q  (dout_q),
    .mode0_q (mode0_q),
    .mode1_q (mode1_q),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  gkb_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pad_in),
    .d_sync  (din_s)
  );

  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    case (ofs)
      OFS_LOCK:                       rd_mux = {lock_on, {(BUS_W-1){1'b0}}};
      OFS_DIN:                        rd_mux = BUS_W'(din_s);
      OFS_MODE1, OFS_M1CLR:           rd_mux = BUS_W'(mode1_q);
      OFS_MODE0, OFS_M0SET, OFS_M0CLR: rd_mux = BUS_W'(mode0_q);
      OFS_DSET, OFS_DCLR:             rd_mux = BUS_W'(dout_q);
      default:                        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && ofs == 8'h20) |=> bus_rdata == '0);

  a_r3_lock_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && ofs == OFS_LOCK) |=> bus_rdata[BUS_W-2:0] == '0);
endmodule

// File: tb/sim_lockgpio_bank.sv
`timescale 1ns/1ps
module sim_lockgpio_bank;
  localparam int unsigned NP = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  lockgpio_bank #(.N_PINS(NP), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out));

  // monitor: pop one expected item per captured read
  initial begin
    forever begin
      bit fire;
      @(posedge clk);
      fire = bus_re && !rst;
      @(negedge clk);
      if (fire) begin
        logic [31:0] e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s: read with no expected item, actual %h expected none", "R10", bus_rdata);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  // all tasks start and end at a negative edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // independent drive table (R2)
  function automatic logic [2*NP-1:0] model_pads(input logic [NP-1:0] m1, m0, d);
    logic [NP-1:0] oe, o;
    for (int i = 0; i < NP; i++) begin
      case ({m1[i], m0[i]})
        2'b01: begin oe[i] = 1'b1;  o[i] = d[i]; end
        2'b10: begin oe[i] = ~d[i]; o[i] = 1'b0; end
        2'b11: begin oe[i] = d[i];  o[i] = d[i]; end
        default: begin oe[i] = 1'b0; o[i] = 1'b0; end
      endcase
    end
    return {oe, o};
  endfunction

  // one extra cycle for the registered pad stage (R11)
  task automatic chk_pads(input logic [NP-1:0] m1, m0, d, input string t);
    logic [2*NP-1:0] e;
    @(negedge clk);
    e = model_pads(m1, m0, d);
    checks++;
    if ({pad_oe, pad_out} !== e) begin
      errors++;
      $display("FAIL %s: oe/out actual %h/%h expected %h/%h", t, pad_oe, pad_out, e[2*NP-1:NP], e[NP-1:0]);
    end
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_pads('0, '0, '0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h0C, 32'h0, "R1");
    rd(8'h08, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    // R5 disarmed mode writes ignored
    wr(8'h54, 32'h3F);
    wr(8'h08, 32'h3F);
    rd(8'h54, 32'h0, "R5");
    rd(8'h08, 32'h0, "R5");
    // R4 other value does not arm; R3 key arms
    wr(8'h00, 32'h1234);
    rd(8'h00, 32'h0, "R4");
    wr(8'h00, 32'h0000D42F);
    rd(8'h00, 32'h8000_0000, "R3");
    wr(8'h00, 32'h55);
    rd(8'h00, 32'h8000_0000, "R4");
    // R6 set aliases, R2 push-pull, R11 timing
    wr(8'h54, 32'h3F);
    wr(8'h14, 32'h05);
    chk_pads(6'h00, 6'h3F, 6'h05, "R2");
    rd(8'h0C, 32'h3F, "R6");
    rd(8'h18, 32'h05, "R10");
    // mixed modes: pin4 high-only, pin5 low-only
    wr(8'h08, 32'h30);
    wr(8'h58, 32'h20);
    chk_pads(6'h30, 6'h1F, 6'h05, "R2");
    wr(8'h14, 32'h30);
    chk_pads(6'h30, 6'h1F, 6'h35, "R2");
    wr(8'h18, 32'h01);
    chk_pads(6'h30, 6'h1F, 6'h34, "R6");
    rd(8'h14, 32'h34, "R6");
    rd(8'h50, 32'h30, "R10");
    wr(8'h50, 32'h10);
    rd(8'h08, 32'h20, "R6");
    // R7 unimplemented bits
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, 32'h3F, "R7");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h3F, "R7");
    wr(8'h08, 32'h0);
    // R4 release, R5 ignored again
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R4");
    wr(8'h58, 32'hFF);
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h1F, "R5");
    chk_pads(6'h00, 6'h1F, 6'h3F, "R5");
    // R9 unmapped
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R9");
    rd(8'h14, 32'h3F, "R9");
    rd(8'h0C, 32'h1F, "R9");
    // R8 synchronizer depth: old, old, new
    pad_in = 6'h2A;
    rd(8'h04, 32'h00, "R8");
    rd(8'h04, 32'h00, "R8");
    rd(8'h04, 32'h2A, "R8");
    pad_in = 6'h15;
    repeat (3) @(negedge clk);
    rd(8'h04, 32'h15, "R8");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule